// File: doc/BRIEF.md
# Strobed Video Clock Source Selector

This block is the digital control logic of a two-output clock generator. A 4-bit video frequency code arrives on input pins and is captured into a holding register only while a strobe input is high. While the strobe is low, the held code stays fixed. Reset clears the held code to zero, so a known frequency is selected before any strobe has occurred.

The held code indexes a 16-entry programmable table. Each entry holds a PLL setting index and a video clock source. The setting index is always presented to the PLL, even when the video output is taken from somewhere else. This keeps the PLL locked at that entry's frequency. The source field decides which clock reaches the video clock output: the PLL output, an external frequency input, or the crystal reference.

A separate 2-bit memory clock select is not gated by the strobe. It maps through a fixed table to a memory PLL setting. All pin inputs pass through two-flop synchronizers on the system clock.

Top module: `clksel_ctrl`

## Requirements
- R1: While reset is active the held video code is 0. After reset, `pll_setting` and `vsrc_sel` show table entry 0 and `mem_setting` reflects `msel_pin`.
- R2: While `strobe_pin` is high, the code on `vsel_pin` reaches the held register within 3 clock cycles after passing through the synchronizers.
- R3: While `strobe_pin` is low, changes on `vsel_pin` have no effect on the held code, `pll_setting` or `vsrc_sel`.
- R4: `pll_setting` equals the setting field (bits [5:0]) of the table entry addressed by the held code.
- R5: The entry source field (bits [7:6]) is decoded as follows: 00 selects the PLL, 01 the external input and 10 the crystal. Code 11 is reserved and acts as PLL. `vsrc_sel` reports the selected source with the same codes and never shows 11.
- R6: When the selected entry routes the external or crystal clock, `pll_setting` still presents that entry's setting.
- R7: `vclk_out` follows `pll_clk`, `ext_clk` or `xtal_clk`, whichever `vsrc_sel` names. The mux is combinational.
- R8: `mem_setting` equals (`msel_pin` + 2) mod 4 within 3 cycles, regardless of the strobe.
- R9: `msel_pin` has no effect on `vsrc_sel` or `pll_setting`.
- R10: A clock edge with `wr_en` high writes `wr_data` into entry `wr_addr`. While `wr_en` is low the table does not change.
- R11: After reset, entry i holds setting (3*i+1) mod 64. Its source is external for i=14, crystal for i=15, and PLL for every other i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on clear, asynchronous |
| vsel_pin | input | 4 | Video frequency code pins |
| strobe_pin | input | 1 | Capture enable for the video code, level-sensitive |
| msel_pin | input | 2 | Memory clock select pins, not strobed |
| wr_en | input | 1 | Table write enable |
| wr_addr | input | 4 | Table entry to write |
| wr_data | input | 8 | Entry value: [7:6] source, [5:0] PLL setting |
| pll_clk | input | 1 | PLL output clock |
| ext_clk | input | 1 | External frequency input clock |
| xtal_clk | input | 1 | Crystal reference clock |
| vclk_out | output | 1 | Video clock output |
| vsrc_sel | output | 2 | Selected video source (00 PLL, 01 external, 10 crystal) |
| pll_setting | output | 6 | PLL setting index for the held code |
| mem_setting | output | 2 | Memory PLL setting |

## Verification
Every one of the 16 codes is strobed in, first against the default table and then against a rewritten table. The rewritten table assigns all four source codes, including the reserved one, and gives each entry a distinct setting, so a wrong index, a wrong decode or a swapped field all show up. For each code, the three clock inputs are driven one-hot in turn: `vclk_out` can only match every pattern if the mux picks the named source. With the strobe held low, the code pins and then the memory select are swept through all values. This separates a gated capture from a leaky one, and shows that the memory path is independent of the video path. Writes with the enable low, and a second reset, show that the table holds its contents and that reset restores the defaults.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
    localparam int VCODE_W = 4;
    localparam int SET_W   = 6;
    localparam int SRC_W   = 2;
    localparam int MEM_W   = 2;
    localparam int ENTRY_W = SRC_W + SET_W;

    typedef enum logic [SRC_W-1:0] {
        SRC_PLL  = 2'b00,
        SRC_EXT  = 2'b01,
        SRC_XTAL = 2'b10,
        SRC_RSV  = 2'b11
    } src_e;

    typedef struct packed {
        src_e               src;
        logic [SET_W-1:0]   setting;
    } entry_t;

    // Reset content of one table entry
    function automatic entry_t default_entry(input int idx, input int depth);
        entry_t e;
        e.setting = SET_W'(3 * idx + 1);
        if (idx == depth - 2)      e.src = SRC_EXT;
        else if (idx == depth - 1) e.src = SRC_XTAL;
        else                       e.src = SRC_PLL;
        return e;
    endfunction
endpackage

// File: rtl/clksel_sync.sv
`timescale 1ns/1ps
module clksel_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/clksel_table.sv
`timescale 1ns/1ps
module clksel_table
    import clksel_pkg::*;
#(
    parameter int ADDR_W = VCODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  entry_t            wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output entry_t            rd_entry
);
    localparam int DEPTH = 1 << ADDR_W;

    entry_t ent_d [DEPTH];
    entry_t ent_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) ent_d[i] = ent_q[i];
        if (wr_en) ent_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= default_entry(i, DEPTH);
        end else begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
        end
    end

    assign rd_entry = ent_q[rd_addr];
endmodule

// File: rtl/clksel_vmux.sv
`timescale 1ns/1ps
module clksel_vmux
    import clksel_pkg::*;
(
    input  src_e             src,
    input  logic             pll_clk,
    input  logic             ext_clk,
    input  logic             xtal_clk,
    output logic             vclk,
    output logic [SRC_W-1:0] sel
);
    always_comb begin
        unique case (src)
            SRC_EXT: begin
                sel  = SRC_EXT;
                vclk = ext_clk;
            end
            SRC_XTAL: begin
                sel  = SRC_XTAL;
                vclk = xtal_clk;
            end
            default: begin
                // reserved code falls back to the PLL
                sel  = SRC_PLL;
                vclk = pll_clk;
            end
        endcase
    end
endmodule

// File: rtl/clksel_ctrl.sv
`timescale 1ns/1ps
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int CODE_W = VCODE_W,
    parameter int MSEL_W = MEM_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CODE_W-1:0]   vsel_pin,
    input  logic                strobe_pin,
    input  logic [MSEL_W-1:0]   msel_pin,
    input  logic                wr_en,
    input  logic [CODE_W-1:0]   wr_addr,
    input  logic [ENTRY_W-1:0]  wr_data,
    input  logic                pll_clk,
    input  logic                ext_clk,
    input  logic                xtal_clk,
    output logic                vclk_out,
    output logic [SRC_W-1:0]    vsrc_sel,
    output logic [SET_W-1:0]    pll_setting,
    output logic [MSEL_W-1:0]   mem_setting
);
    localparam int MEM_DEPTH = 1 << MSEL_W;
    localparam int MEM_OFS   = 2;

    logic [CODE_W-1:0] vsel_s;
    logic              strobe_s;
    logic [MSEL_W-1:0] msel_s;

    clksel_sync #(.WIDTH(CODE_W)) u_vsync (
        .clk(clk), .rst_n(rst_n), .din(vsel_pin), .dout(vsel_s)
    );
    clksel_sync #(.WIDTH(1)) u_ssync (
        .clk(clk), .rst_n(rst_n), .din(strobe_pin), .dout(strobe_s)
    );
    clksel_sync #(.WIDTH(MSEL_W)) u_msync (
        .clk(clk), .rst_n(rst_n), .din(msel_pin), .dout(msel_s)
    );

    // Strobe-gated code holder, cleared by power-on reset
    typedef struct packed {
        logic [CODE_W-1:0] held;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (strobe_s) ctl_d.held = vsel_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    logic [CODE_W-1:0] held_q;
    assign held_q = ctl_q.held;

    entry_t cur_entry;

    clksel_table #(.ADDR_W(CODE_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (entry_t'(wr_data)),
        .rd_addr  (held_q),
        .rd_entry (cur_entry)
    );

    clksel_vmux u_vmux (
        .src      (cur_entry.src),
        .pll_clk  (pll_clk),
        .ext_clk  (ext_clk),
        .xtal_clk (xtal_clk),
        .vclk     (vclk_out),
        .sel      (vsrc_sel)
    );

    assign pll_setting = cur_entry.setting;

    // Fixed memory setting table, offset mapping
    logic [MSEL_W-1:0] mem_lut [MEM_DEPTH];
    for (genvar g = 0; g < MEM_DEPTH; g++) begin : g_memlut
        assign mem_lut[g] = MSEL_W'(g + MEM_OFS);
    end

    assign mem_setting = mem_lut[msel_s];
endmodule

// File: rtl/clksel_ctrl_chk.sv
`timescale 1ns/1ps
module clksel_ctrl_chk #(
    parameter int CODE_W = 4,
    parameter int MSEL_W = 2,
    parameter int SET_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe_s,
    input logic [CODE_W-1:0] vsel_s,
    input logic [CODE_W-1:0] held_q,
    input logic [MSEL_W-1:0] msel_s,
    input logic              wr_en,
    input logic [1:0]        vsrc_sel,
    input logic              vclk_out,
    input logic              pll_clk,
    input logic              ext_clk,
    input logic              xtal_clk,
    input logic [SET_W-1:0]  pll_setting,
    input logic [MSEL_W-1:0] mem_setting
);
    // R3
    hold_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_s |=> $stable(held_q));

    // R2
    load_when_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_s |=> held_q == $past(vsel_s));

    // R5
    sel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vsrc_sel != 2'b11);

    // R7
    vclk_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vsrc_sel == 2'b00 |-> vclk_out == pll_clk);

    // R7
    vclk_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vsrc_sel == 2'b01 |-> vclk_out == ext_clk);

    // R7
    vclk_xtal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vsrc_sel == 2'b10 |-> vclk_out == xtal_clk);

    // R8
    mem_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_setting == MSEL_W'(msel_s + MSEL_W'(2)));

    // R10
    table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !strobe_s) |=> $stable(pll_setting) && $stable(vsrc_sel));
endmodule

bind clksel_ctrl clksel_ctrl_chk #(
    .CODE_W (CODE_W),
    .MSEL_W (MSEL_W),
    .SET_W  (clksel_pkg::SET_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_s    (strobe_s),
    .vsel_s      (vsel_s),
    .held_q      (held_q),
    .msel_s      (msel_s),
    .wr_en       (wr_en),
    .vsrc_sel    (vsrc_sel),
    .vclk_out    (vclk_out),
    .pll_clk     (pll_clk),
    .ext_clk     (ext_clk),
    .xtal_clk    (xtal_clk),
    .pll_setting (pll_setting),
    .mem_setting (mem_setting)
);

// File: tb/clksel_ctrl_test.sv
`timescale 1ns/1ps
module clksel_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] vsel_pin = '0;
    logic       strobe_pin = 1'b0;
    logic [1:0] msel_pin = '0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pll_clk = 1'b0, ext_clk = 1'b0, xtal_clk = 1'b0;
    logic       vclk_out;
    logic [1:0] vsrc_sel;
    logic [5:0] pll_setting;
    logic [1:0] mem_setting;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    clksel_ctrl uut (
        .clk(clk), .rst_n(rst_n), .vsel_pin(vsel_pin), .strobe_pin(strobe_pin),
        .msel_pin(msel_pin), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pll_clk(pll_clk), .ext_clk(ext_clk), .xtal_clk(xtal_clk),
        .vclk_out(vclk_out), .vsrc_sel(vsrc_sel), .pll_setting(pll_setting),
        .mem_setting(mem_setting)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int dflt_set(input int i);
        return (3 * i + 1) % 64;
    endfunction

    function automatic int dflt_src(input int i);
        return (i == 14) ? 1 : (i == 15) ? 2 : 0;
    endfunction

    function automatic int norm_src(input int s);
        return (s == 3) ? 0 : s;
    endfunction

    task automatic load_code(input int c);
        @(negedge clk);
        vsel_pin = 4'(c);
        strobe_pin = 1'b1;
        repeat (4) @(negedge clk);
        strobe_pin = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // drive one-hot clock levels and compare the output level
    task automatic check_mux(input int src, input string tag);
        for (int p = 0; p < 3; p++) begin
            pll_clk  = (p == 0);
            ext_clk  = (p == 1);
            xtal_clk = (p == 2);
            #1;
            check(vclk_out == (src == p), tag, int'(vclk_out), int'(src == p));
        end
    endtask

    task automatic sweep_codes(input bit custom, input string tag);
        for (int c = 0; c < 16; c++) begin
            int es, ep;
            load_code(c);
            es = custom ? norm_src(c % 4) : dflt_src(c);
            ep = custom ? 63 - c : dflt_set(c);
            // R4 R6
            check(int'(pll_setting) == ep, {tag, " R4/R6 setting"}, int'(pll_setting), ep);
            // R5
            check(int'(vsrc_sel) == es, {tag, " R5 source"}, int'(vsrc_sel), es);
            // R7
            check_mux(es, {tag, " R7 vclk"});
        end
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int held_set, held_src;
        repeat (3) @(negedge clk);
        // R1
        check(pll_setting == 6'd1 && vsrc_sel == 2'd0, "R1 reset entry", int'(pll_setting), 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(int'(pll_setting) == dflt_set(0), "R1 held zero after reset", int'(pll_setting), dflt_set(0));
        check(int'(mem_setting) == 2, "R1 mem after reset", int'(mem_setting), 2);

        // R2 R11 default table sweep
        sweep_codes(1'b0, "R2 R11 default");

        // R3 strobe low: code pins ignored
        load_code(5);
        for (int c = 0; c < 16; c++) begin
            vsel_pin = 4'(c);
            repeat (4) @(negedge clk);
            check(int'(pll_setting) == dflt_set(5), "R3 pins ignored", int'(pll_setting), dflt_set(5));
            check(vsrc_sel == 2'd0, "R3 source held", int'(vsrc_sel), 0);
        end

        // R8 R9 memory select, strobe low, video held at code 14
        load_code(14);
        for (int m = 0; m < 4; m++) begin
            msel_pin = 2'(m);
            repeat (3) @(negedge clk);
            check(int'(mem_setting) == (m + 2) % 4, "R8 mem map", int'(mem_setting), (m + 2) % 4);
            check(int'(pll_setting) == dflt_set(14) && vsrc_sel == 2'd1, "R9 video untouched",
                  int'(pll_setting), dflt_set(14));
        end
        // R8 also with strobe high
        strobe_pin = 1'b1;
        msel_pin = 2'd3;
        repeat (3) @(negedge clk);
        check(int'(mem_setting) == 1, "R8 mem with strobe", int'(mem_setting), 1);
        strobe_pin = 1'b0;
        repeat (3) @(negedge clk);

        // R10 rewrite the whole table
        for (int i = 0; i < 16; i++) begin
            wr_en = 1'b1;
            wr_addr = 4'(i);
            wr_data = {2'(i % 4), 6'(63 - i)};
            @(negedge clk);
        end
        wr_en = 1'b0;
        sweep_codes(1'b1, "R10 custom");

        // R10 write with enable low leaves entry alone (held code is 15)
        held_set = 63 - 15;
        held_src = norm_src(15 % 4);
        wr_addr = 4'd15;
        wr_data = {2'd1, 6'd9};
        repeat (3) @(negedge clk);
        check(int'(pll_setting) == held_set && int'(vsrc_sel) == held_src, "R10 no write when disabled",
              int'(pll_setting), held_set);
        // live write to the held entry
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check(pll_setting == 6'd9 && vsrc_sel == 2'd1, "R10 live write", int'(pll_setting), 9);

        // R1 R11 second reset restores defaults and code zero
        rst_n = 1'b0;
        @(negedge clk);
        check(int'(pll_setting) == dflt_set(0) && vsrc_sel == 2'd0, "R11 defaults restored",
              int'(pll_setting), dflt_set(0));
        rst_n = 1'b1;
        load_code(15);
        check(int'(pll_setting) == dflt_set(15) && vsrc_sel == 2'd2, "R11 entry 15 default",
              int'(pll_setting), dflt_set(15));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule